// File: doc/BRIEF.md
# Six-Channel Mode-Selectable Timer

This peripheral holds six independent 32-bit up-counters behind a small register bus. Software picks a run mode for each channel: stop after one match, restart from zero on every match, or run freely and wrap. Each channel also picks one of two tick inputs and an optional divide-by-two. Those two tick-enable inputs stand in for the clock generator. A channel whose count reaches its compare value latches a pending flag. One shared register masks which flags reach the single interrupt line, and another shared register acknowledges them.

Channels are numbered 1 to 6. Channel n owns four registers, starting at byte offset 16·n. The shared enable and acknowledge registers sit below offset 0x10. Writes take effect on the rising clock edge that samples `wr_en`. Reads are combinational from `addr`.

Top module: `gp_timer6`

## Requirements
- R1: After reset every register reads 0 and `irq` is low. The registers are enables, pending, control, clock select, count and compare.
- R2: An enabled channel adds one to its count on each selected tick. Clock register (offset 16·n+4) bit 4 picks the tick: 0 selects `tick_fast` and 1 selects `tick_slow`. The tick that is not selected has no effect.
- R3: With clock register bit 0 set, the count advances only on every second selected tick after a clear (the 2nd, 4th and so on).
- R4: Writing 1 to control bit 1 (control register at offset 16·n) sets the count to 0 and restarts the divider phase. This bit always reads back as 0. Control bit 0 is the enable and bits 5:4 are the mode.
- R5: In mode 0 (one-shot) the channel stops when the count steps onto the compare value (offset 16·n+12). The count holds that value, the enable bit reads 0, and pending bit n-1 is set.
- R6: In mode 1 (repeat) a step onto the compare value sets pending bit n-1 and returns the count to 0. Counting then carries on.
- R7: In mode 3 (free-running) the count wraps from 0xFFFFFFFF to 0 and never sets a pending bit. Mode 2 acts the same way.
- R8: Writing 1 to bit n-1 of the register at offset 0x08 clears pending flag n-1. Writing 0x3f clears all six flags. Reading offset 0x08 returns the pending flags. A match in the same cycle as the clear wins over it.
- R9: `irq` is high exactly when some pending flag has its bit set in the enable register at offset 0x00.
- R10: The count register (offset 16·n+8) takes software writes. A disabled channel holds its count while ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_fast | input | 1 | Tick enable of the fast timebase |
| tick_slow | input | 1 | Tick enable of the slow timebase |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
Assertions check the following on every cycle:
- a clear leaves the count at zero;
- a disabled channel holds its count;
- a one-shot match drops the enable;
- pending flags never rise in a free-running mode;
- an acknowledge removes a flag unless a match lands in the same cycle;
- `irq` never rises without an enable bit.

Only the bench scenarios can show the actual count values. These cover tick source selection, the divide-by-two phase, the wrap at 2^32 and the repeat period for random compare values and tick counts.

// File: rtl/gp_timer6.sv
module gp_timer6 #(
  parameter int NCH = 6,
  parameter int CW  = 32,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_fast,
  input  logic          tick_slow,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq
);
  localparam int CH_AW = AW - 4;

  logic [NCH-1:0] ien, pend, hit, en, src, div, phase;
  logic [1:0]     mode [NCH];
  logic [CW-1:0]  cnt  [NCH];
  logic [CW-1:0]  cmp  [NCH];
  logic [31:0]    rd_ch [NCH];
  logic [NCH-1:0] rd_hit;

  wire shared_blk = (addr[AW-1:4] == '0);
  wire wr_ien = wr_en && shared_blk && addr[3:0] == 4'h0;
  wire wr_ack = wr_en && shared_blk && addr[3:0] == 4'h8;
  wire [NCH-1:0] ack_mask = wr_ack ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ien  <= '0;
      pend <= '0;
    end else begin
      if (wr_ien) ien <= wdata[NCH-1:0];
      pend <= (pend & ~ack_mask) | hit;
    end

  assign irq = |(pend & ien);

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|ien)); // R9

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire chsel   = (addr[AW-1:4] == CH_AW'(i + 1));
    wire wr_ctrl = wr_en && chsel && addr[3:2] == 2'd0;
    wire wr_clk  = wr_en && chsel && addr[3:2] == 2'd1;
    wire wr_cnt  = wr_en && chsel && addr[3:2] == 2'd2;
    wire wr_cmp  = wr_en && chsel && addr[3:2] == 2'd3;
    wire tk      = src[i] ? tick_slow : tick_fast;
    wire step    = en[i] && tk && (!div[i] || phase[i]);
    wire [CW-1:0] nxt = cnt[i] + 1'b1;
    wire match   = step && !mode[i][1] && nxt == cmp[i];

    assign hit[i]    = match;
    assign rd_hit[i] = chsel;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        en[i] <= 1'b0; mode[i] <= 2'd0; src[i] <= 1'b0; div[i] <= 1'b0;
        phase[i] <= 1'b0; cnt[i] <= '0; cmp[i] <= '0;
      end else begin
        if (wr_ctrl) begin
          en[i]   <= wdata[0];
          mode[i] <= wdata[5:4];
        end else if (match && !mode[i][0]) begin
          en[i] <= 1'b0;
        end
        if (wr_clk) begin
          src[i] <= wdata[4];
          div[i] <= wdata[0];
        end
        if (wr_cmp) cmp[i] <= wdata[CW-1:0];
        if (wr_ctrl && wdata[1]) begin
          cnt[i]   <= '0;
          phase[i] <= 1'b0;
        end else begin
          if (en[i] && tk && div[i]) phase[i] <= ~phase[i];
          if (wr_cnt)    cnt[i] <= wdata[CW-1:0];
          else if (step) cnt[i] <= (match && mode[i][0]) ? '0 : nxt;
        end
      end

    always_comb
      case (addr[3:2])
        2'd0:    rd_ch[i] = {26'd0, mode[i], 3'd0, en[i]};
        2'd1:    rd_ch[i] = {27'd0, src[i], 3'd0, div[i]};
        2'd2:    rd_ch[i] = 32'(cnt[i]);
        default: rd_ch[i] = 32'(cmp[i]);
      endcase

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wdata[1]) |=> cnt[i] == '0); // R4
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[i] && !wr_ctrl && !wr_cnt) |=> $stable(cnt[i])); // R10
    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && mode[i] == 2'd0 && !wr_ctrl) |=> !en[i]); // R5
    AST_FREE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i][1] && !pend[i]) |=> !pend[i]); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_mask[i] && !hit[i]) |=> !pend[i]); // R8
  end

  always_comb begin
    rdata = '0;
    if (shared_blk) begin
      if (addr[3:0] == 4'h0) rdata = 32'(ien);
      else if (addr[3:0] == 4'h8) rdata = 32'(pend);
    end
    for (int i = 0; i < NCH; i++)
      if (rd_hit[i]) rdata = rd_ch[i];
  end
endmodule

// File: tb/gp_timer6_test.sv
module gp_timer6_test;
  logic clk = 1'b0, rst_n = 1'b0, tick_fast = 1'b0, tick_slow = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int nchk = 0, nerr = 0;

  gp_timer6 uut (.clk, .rst_n, .tick_fast, .tick_slow, .wr_en, .addr, .wdata, .rdata, .irq);

  always #5 clk = ~clk;

  function automatic logic [7:0] a_ctrl(int n); return 8'(16 * n); endfunction
  function automatic logic [7:0] a_clk(int n);  return 8'(16 * n + 4); endfunction
  function automatic logic [7:0] a_cnt(int n);  return 8'(16 * n + 8); endfunction
  function automatic logic [7:0] a_cmp(int n);  return 8'(16 * n + 12); endfunction
  function automatic logic [31:0] exp_rep_cnt(int t, int c); return 32'(t % c); endfunction
  function automatic logic exp_rep_pend(int t, int c); return t >= c; endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic ticks(bit slow, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); if (slow) tick_slow = 1'b1; else tick_fast = 1'b1;
      @(negedge clk); tick_slow = 1'b0; tick_fast = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(8'h00, d); chk("R1 enable reg", d, 0);
    rd(8'h08, d); chk("R1 pending reg", d, 0);
    rd(a_ctrl(1), d); chk("R1 ctrl ch1", d, 0);
    rd(a_cnt(6), d); chk("R1 count ch6", d, 0);
    rd(a_cmp(3), d); chk("R1 compare ch3", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    wr(a_cmp(1), 32'hFFFF);
    wr(a_ctrl(1), 32'h33);
    ticks(0, 5); rd(a_cnt(1), d); chk("R2 fast ticks", d, 5);
    ticks(1, 3); rd(a_cnt(1), d); chk("R2 slow ignored", d, 5);
    wr(a_clk(1), 32'h10);
    ticks(1, 4); rd(a_cnt(1), d); chk("R2 slow ticks", d, 9);
    ticks(0, 2); rd(a_cnt(1), d); chk("R2 fast ignored", d, 9);

    wr(a_clk(2), 32'h01);
    wr(a_ctrl(2), 32'h33);
    ticks(0, 7); rd(a_cnt(2), d); chk("R3 divide by two", d, 3);
    ticks(0, 1); rd(a_cnt(2), d); chk("R3 even tick", d, 4);

    wr(a_ctrl(2), 32'h33);
    rd(a_cnt(2), d); chk("R4 clear zeroes", d, 0);
    rd(a_ctrl(2), d); chk("R4 clear reads 0", d, 32'h31);
    ticks(0, 1); rd(a_cnt(2), d); chk("R4 phase restart", d, 0);

    wr(a_ctrl(3), 32'h31);
    wr(a_cnt(3), 32'hFFFF_FFFE);
    ticks(0, 3); rd(a_cnt(3), d); chk("R7 wrap", d, 1);
    rd(8'h08, d); chk("R7 no pending", d & 32'h4, 0);

    wr(a_cmp(4), 4);
    wr(8'h00, 32'h08);
    wr(a_ctrl(4), 32'h03);
    ticks(0, 3); rd(a_cnt(4), d); chk("R5 before match", d, 3);
    rd(8'h08, d); chk("R5 not pending yet", d & 32'h8, 0);
    chk("R9 irq idle", {31'd0, irq}, 0);
    ticks(0, 1); rd(a_cnt(4), d); chk("R5 count at compare", d, 4);
    rd(8'h08, d); chk("R5 pending set", d & 32'h8, 32'h8);
    rd(a_ctrl(4), d); chk("R5 enable cleared", d, 0);
    chk("R9 irq raised", {31'd0, irq}, 1);
    ticks(0, 2); rd(a_cnt(4), d); chk("R10 disabled holds", d, 4);

    wr(8'h00, 32'h00); #1 chk("R9 masked", {31'd0, irq}, 0);
    wr(8'h00, 32'h08); #1 chk("R9 unmasked", {31'd0, irq}, 1);
    wr(8'h08, 32'h3f);
    rd(8'h08, d); chk("R8 ack all", d, 0);
    chk("R8 irq after ack", {31'd0, irq}, 0);

    wr(a_cmp(5), 3);
    wr(a_ctrl(5), 32'h13);
    ticks(0, 3); rd(a_cnt(5), d); chk("R6 reload", d, 0);
    rd(8'h08, d); chk("R6 pending", d & 32'h10, 32'h10);
    ticks(0, 2); rd(a_cnt(5), d); chk("R6 keeps running", d, 2);
    wr(8'h08, 32'h10);
    rd(8'h08, d); chk("R8 single ack", d & 32'h10, 0);
    wr(a_ctrl(5), 32'h00);

    wr(a_cnt(6), 32'h1234);
    ticks(0, 3); rd(a_cnt(6), d); chk("R10 count write held", d, 32'h1234);

    for (int it = 0; it < 25; it++) begin
      int ch = 1 + int'($urandom_range(5, 0));
      int c  = 2 + int'($urandom_range(38, 0));
      int t  = int'($urandom_range(60, 0));
      wr(a_cmp(ch), 32'(c));
      wr(a_clk(ch), 32'h0);
      wr(a_ctrl(ch), 32'h13);
      wr(8'h08, 32'(1) << (ch - 1));
      ticks(0, t);
      rd(a_cnt(ch), d); chk("R6 random count", d, exp_rep_cnt(t, c));
      rd(8'h08, d);
      chk("R6 random pending", 32'(d[ch-1]), 32'(exp_rep_pend(t, c)));
      wr(a_ctrl(ch), 32'h0);
    end

    finish_run();
  end
endmodule